// File: doc/BRIEF.md
# Checksummed Loader Image Receiver

This block takes a loader image from a byte stream and writes it into memory. Each frame starts with a seven-byte header. The header gives a destination address, a payload byte count and a check byte. The block captures the header and compares the check byte with its own running sum. It then returns the check byte to the sender as an acknowledgement, and it does this whether or not the two agree.

The block then accepts the stated number of payload bytes. It writes each one to the next memory location, starting from a fixed logical base of 0x6000. The sender must open the payload with the marker byte 0xCC. The block stores that marker as 0x00 in its place. Two trailing bytes carry a Fletcher-8 check over the payload as it was received. When the second of these bytes arrives, the block raises a one-cycle completion pulse and updates its image-check flag. It also shows the execution entry address.

Top module: `ldr_image_rx`

## Requirements
- R1: While reset is held and until the first byte arrives, `in_ready` is 1 and `out_valid`, `wr_en`, `done`, `hdr_ok`, `marker_ok` and `image_ok` are all 0.
- R2: Header bytes 0..3 form `dest_addr` and bytes 4..5 form the payload length. Both fields are taken least significant byte first, and `dest_addr` shows the captured value once the header is complete.
- R3: `hdr_ok` is set to 1 exactly when header byte 6 equals the 8-bit wrapping sum of header bytes 0..5. It is updated in the cycle after byte 6 is accepted.
- R4: After header byte 6 is accepted, `out_valid` goes to 1 with `out_data` equal to that byte, whether or not it matched. Both hold until `out_ready` is seen high. `in_ready` stays 0 for as long as `out_valid` is 1.
- R5: Payload byte k (counted from 0) causes exactly one `wr_en` pulse, in the cycle after it is accepted, with `wr_addr` = 0x6000 + k.
- R6: If payload byte 0 is 0xCC, it is written as 0x00 and `marker_ok` becomes 1. Any other first byte is written unchanged and `marker_ok` becomes 0. All later payload bytes are written unchanged.
- R7: The block keeps sum1 += byte and sum2 += sum1, both modulo 255, starting from 0, over the payload bytes as received (a marker counts as 0xCC). `image_ok` is 1 exactly when the first trailing byte equals sum1 and the second equals sum2.
- R8: In the cycle after the second trailing byte is accepted, `done` is 1 for exactly one cycle and `image_ok` takes its new value. `image_ok` changes only together with `done`. `exec_addr` reads 0x6000.
- R9: A length of 0 produces no writes. The block goes straight from the acknowledgement to the two trailing bytes, expects 0x00 and 0x00 for them, and clears `marker_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming byte present |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Block accepts the incoming byte this cycle |
| out_valid | output | 1 | Acknowledgement byte present |
| out_data | output | 8 | Acknowledgement byte (echoed header check byte) |
| out_ready | input | 1 | Sender takes the acknowledgement |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 8 | Memory write data |
| dest_addr | output | 32 | Captured physical destination address |
| exec_addr | output | 16 | Execution entry address (logical base) |
| hdr_ok | output | 1 | Header check matched |
| marker_ok | output | 1 | First payload byte was the marker |
| image_ok | output | 1 | Trailing Fletcher-8 bytes matched |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
Random frames with random lengths and random payload contents show whether the write addressing and the Fletcher sums track the byte order correctly. Random corruption of the header check byte or of the second trailing byte shows that each flag follows its own check and not the other. Directed frames cover four cases: a non-marker first byte, a zero-length payload, a long run of 0xFF bytes, and a late acknowledgement. The 0xFF run matters because 0xFF is congruent to 0 modulo 255, so it separates a correct mod-255 reduction from a plain 8-bit wrap. The late acknowledgement shows that the echoed byte is held and that input stays blocked while it waits.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   typedef enum logic [2:0] {
      ST_HDR  = 3'd0,
      ST_ECHO = 3'd1,
      ST_PAY  = 3'd2,
      ST_CK1  = 3'd3,
      ST_CK2  = 3'd4
   } ldr_state_t;

   // addition modulo 255 on operands already reduced to 0..254 (b may be 255)
   function automatic logic [7:0] add_m255(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] t;
      t = {1'b0, a} + {1'b0, b};
      if (t >= 9'd255) t = t - 9'd255;
      return t[7:0];
   endfunction

endpackage

// File: rtl/ldr_hdr_capture.sv
module ldr_hdr_capture #(
   parameter int DEST_BYTES = 4,
   parameter int LEN_BYTES  = 2,
   parameter int IDX_W      = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take,
   input  logic [IDX_W-1:0]         idx,
   input  logic [7:0]               din,
   output logic [DEST_BYTES*8-1:0]  dest,
   output logic [LEN_BYTES*8-1:0]   len,
   output logic [7:0]               sum
);
   localparam int FIELD_BYTES = DEST_BYTES + LEN_BYTES;

   // one register per byte lane, little-endian placement
   for (genvar lane = 0; lane < DEST_BYTES; lane++) begin : g_dest
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else if (take && idx == IDX_W'(lane)) q <= din;
      end
      assign dest[lane*8 +: 8] = q;
   end

   for (genvar lane = 0; lane < LEN_BYTES; lane++) begin : g_len
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else if (take && idx == IDX_W'(DEST_BYTES + lane)) q <= din;
      end
      assign len[lane*8 +: 8] = q;
   end

   // wrapping byte sum over the address and length fields
   always_ff @(posedge clk) begin
      if (!rst_n) sum <= '0;
      else if (take) begin
         if (idx == '0) sum <= din;
         else if (idx < IDX_W'(FIELD_BYTES)) sum <= sum + din;
      end
   end

endmodule

// File: rtl/ldr_fletcher8.sv
module ldr_fletcher8
   import ldr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       take,
   input  logic [7:0] din,
   output logic [7:0] s1,
   output logic [7:0] s2
);
   logic [7:0] s1_nx;

   assign s1_nx = add_m255(s1, din);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         s1 <= '0;
         s2 <= '0;
      end else if (take) begin
         s1 <= s1_nx;
         s2 <= add_m255(s2, s1_nx);
      end
   end

endmodule

// File: rtl/ldr_pay_writer.sv
module ldr_pay_writer #(
   parameter int          ADDR_W   = 16,
   parameter int          LEN_W    = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'h6000,
   parameter logic [7:0]  MARKER   = 8'hCC,
   parameter logic [7:0]  MARK_STO = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [LEN_W-1:0]  idx,
   input  logic [7:0]        din,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   logic first;
   assign first = (idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= take;
         if (take) begin
            wr_addr <= BASE + ADDR_W'(idx);
            wr_data <= (first && din == MARKER) ? MARK_STO : din;
         end
      end
   end

endmodule

// File: rtl/ldr_image_rx.sv
module ldr_image_rx
   import ldr_pkg::*;
#(
   parameter int          DEST_BYTES = 4,
   parameter int          LEN_BYTES  = 2,
   parameter int          ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'h6000,
   parameter logic [7:0]  MARKER     = 8'hCC,
   parameter logic [7:0]  MARK_STO   = 8'h00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [7:0]              in_data,
   output logic                    in_ready,
   output logic                    out_valid,
   output logic [7:0]              out_data,
   input  logic                    out_ready,
   output logic                    wr_en,
   output logic [ADDR_W-1:0]       wr_addr,
   output logic [7:0]              wr_data,
   output logic [DEST_BYTES*8-1:0] dest_addr,
   output logic [ADDR_W-1:0]       exec_addr,
   output logic                    hdr_ok,
   output logic                    marker_ok,
   output logic                    image_ok,
   output logic                    done
);
   localparam int HDR_BYTES = DEST_BYTES + LEN_BYTES + 1;
   localparam int IDX_W     = $clog2(HDR_BYTES);
   localparam int LEN_W     = LEN_BYTES * 8;

   if (DEST_BYTES < 1 || DEST_BYTES > 8) begin : g_bad_dest
      $error("ldr_image_rx: DEST_BYTES out of range");
   end
   if (LEN_BYTES < 1 || LEN_BYTES > 4) begin : g_bad_len
      $error("ldr_image_rx: LEN_BYTES out of range");
   end
   if (ADDR_W < LEN_W) begin : g_bad_addr
      $error("ldr_image_rx: ADDR_W must cover the length field");
   end

   ldr_state_t       state;
   logic [IDX_W-1:0] hdr_idx;
   logic [LEN_W-1:0] pay_idx;
   logic [LEN_W-1:0] pay_len;
   logic [7:0]       hdr_sum;
   logic [7:0]       echo_q;
   logic [7:0]       fl_s1, fl_s2;
   logic             ck1_ok;
   logic             acc, acc_hdr, acc_pay, echo_take, pay_last;

   assign in_ready  = (state != ST_ECHO);
   assign out_valid = (state == ST_ECHO);
   assign out_data  = echo_q;
   assign exec_addr = BASE;

   assign acc       = in_valid && in_ready;
   assign acc_hdr   = acc && (state == ST_HDR);
   assign acc_pay   = acc && (state == ST_PAY);
   assign echo_take = (state == ST_ECHO) && out_ready;
   assign pay_last  = ((pay_idx + LEN_W'(1)) == pay_len);

   ldr_hdr_capture #(
      .DEST_BYTES(DEST_BYTES),
      .LEN_BYTES (LEN_BYTES),
      .IDX_W     (IDX_W)
   ) u_hdr (
      .clk  (clk),
      .rst_n(rst_n),
      .take (acc_hdr),
      .idx  (hdr_idx),
      .din  (in_data),
      .dest (dest_addr),
      .len  (pay_len),
      .sum  (hdr_sum)
   );

   ldr_fletcher8 u_fl (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (echo_take),
      .take (acc_pay),
      .din  (in_data),
      .s1   (fl_s1),
      .s2   (fl_s2)
   );

   ldr_pay_writer #(
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .BASE    (BASE),
      .MARKER  (MARKER),
      .MARK_STO(MARK_STO)
   ) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (acc_pay),
      .idx    (pay_idx),
      .din    (in_data),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_HDR;
         hdr_idx   <= '0;
         pay_idx   <= '0;
         echo_q    <= '0;
         ck1_ok    <= 1'b0;
         hdr_ok    <= 1'b0;
         marker_ok <= 1'b0;
         image_ok  <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_HDR: if (acc) begin
               if (hdr_idx == IDX_W'(HDR_BYTES - 1)) begin
                  echo_q  <= in_data;
                  hdr_ok  <= (in_data == hdr_sum);
                  hdr_idx <= '0;
                  state   <= ST_ECHO;
               end else begin
                  hdr_idx <= hdr_idx + IDX_W'(1);
               end
            end
            ST_ECHO: if (out_ready) begin
               pay_idx <= '0;
               if (pay_len == '0) begin
                  marker_ok <= 1'b0;
                  state     <= ST_CK1;
               end else begin
                  state <= ST_PAY;
               end
            end
            ST_PAY: if (acc) begin
               if (pay_idx == '0) marker_ok <= (in_data == MARKER);
               if (pay_last) state <= ST_CK1;
               pay_idx <= pay_idx + LEN_W'(1);
            end
            ST_CK1: if (acc) begin
               ck1_ok <= (in_data == fl_s1);
               state  <= ST_CK2;
            end
            ST_CK2: if (acc) begin
               image_ok <= ck1_ok && (in_data == fl_s2);
               done     <= 1'b1;
               state    <= ST_HDR;
            end
            default: state <= ST_HDR;
         endcase
      end
   end

endmodule

// File: rtl/ldr_image_rx_chk.sv
module ldr_image_rx_chk #(
   parameter int          ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'h6000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [7:0]        in_data,
   input logic              in_ready,
   input logic              out_valid,
   input logic [7:0]        out_data,
   input logic              out_ready,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              image_ok,
   input logic              done
);
   logic              seen;
   logic [ADDR_W-1:0] last_addr;

   always_ff @(posedge clk) begin
      if (!rst_n || done) begin
         seen      <= 1'b0;
         last_addr <= '0;
      end else if (wr_en) begin
         seen      <= 1'b1;
         last_addr <= wr_addr;
      end
   end

   p_first_write_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !seen |-> wr_addr == BASE);

   p_write_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && seen |-> wr_addr == last_addr + ADDR_W'(1));

   p_write_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(in_valid && in_ready));

   p_marker_replaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !seen && $past(in_data) == 8'hCC |-> wr_data == 8'h00);

   p_echo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   p_echo_blocks_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_image_flag_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(image_ok));

endmodule

bind ldr_image_rx ldr_image_rx_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_data  (in_data),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_ready(out_ready),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .image_ok (image_ok),
   .done     (done)
);

// File: tb/ldr_image_rx_test.sv
module ldr_image_rx_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] BASE = 16'h6000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready = 1'b0;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic [31:0] dest_addr;
   logic [15:0] exec_addr;
   logic        hdr_ok, marker_ok, image_ok, done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int wr_count = 0;
   int exp_len = 0;
   logic [7:0] exp_mem [0:63];

   always #(CLK_PERIOD/2) clk = ~clk;

   ldr_image_rx uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dest_addr(dest_addr), .exec_addr(exec_addr), .hdr_ok(hdr_ok),
      .marker_ok(marker_ok), .image_ok(image_ok), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] m255(input logic [7:0] a, input logic [7:0] b);
      int t;
      t = (int'(a) + int'(b)) % 255;
      return t[7:0];
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   // write monitor: R5 addressing, R6 stored value
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (wr_count >= exp_len) begin
            check(1'b0, "R5 unexpected write", 32'(wr_count), 32'(exp_len));
         end else begin
            check(wr_addr == BASE + 16'(wr_count), "R5 write address",
                  32'(wr_addr), 32'(BASE + 16'(wr_count)));
            check(wr_data == exp_mem[wr_count], "R6 write data",
                  32'(wr_data), 32'(exp_mem[wr_count]));
         end
         wr_count++;
      end
   end

   task automatic send_byte(input logic [7:0] b);
      bit taken = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      while (!taken) begin
         taken = in_ready;
         @(posedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic run_frame(input logic [31:0] dest, input int len, input bit bad_hdr,
                            input logic [7:0] first, input bit bad_img, input int delay,
                            input bit all_ff);
      logic [7:0] p [0:63];
      logic [7:0] h [0:6];
      logic [7:0] sum, s1, s2;
      for (int k = 0; k < 64; k++) p[k] = all_ff ? 8'hFF : 8'($urandom);
      p[0] = first;
      h[0] = dest[7:0];   h[1] = dest[15:8];
      h[2] = dest[23:16]; h[3] = dest[31:24];
      h[4] = 8'(len);     h[5] = 8'(len >> 8);
      sum = '0;
      for (int k = 0; k < 6; k++) sum = sum + h[k];
      h[6] = bad_hdr ? sum + 8'h33 : sum;
      for (int k = 0; k < 7; k++) send_byte(h[k]);
      check(out_valid == 1'b1, "R4 echo valid", 32'(out_valid), 32'd1);
      check(out_data == h[6], "R4 echo byte", 32'(out_data), 32'(h[6]));
      check(in_ready == 1'b0, "R4 input blocked", 32'(in_ready), 32'd0);
      check(hdr_ok == !bad_hdr, "R3 header flag", 32'(hdr_ok), 32'(!bad_hdr));
      check(dest_addr == dest, "R2 destination", dest_addr, dest);
      for (int d = 0; d < delay; d++) begin
         @(negedge clk);
         check(out_valid && out_data == h[6] && !in_ready, "R4 echo held",
               32'(out_data), 32'(h[6]));
      end
      for (int k = 0; k < len; k++) exp_mem[k] = p[k];
      if (len > 0 && p[0] == 8'hCC) exp_mem[0] = 8'h00;
      exp_len  = len;
      wr_count = 0;
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      s1 = '0;
      s2 = '0;
      for (int k = 0; k < len; k++) begin
         send_byte(p[k]);
         s1 = m255(s1, p[k]);
         s2 = m255(s2, s1);
      end
      send_byte(s1);
      send_byte(bad_img ? (s2 ^ 8'h01) : s2);
      check(done == 1'b1, "R8 done pulse", 32'(done), 32'd1);
      check(image_ok == !bad_img, "R7 image flag", 32'(image_ok), 32'(!bad_img));
      check(marker_ok == (len > 0 && first == 8'hCC), "R6 R9 marker flag",
            32'(marker_ok), 32'(len > 0 && first == 8'hCC));
      check(exec_addr == BASE, "R8 entry address", 32'(exec_addr), 32'(BASE));
      check(wr_count == len, "R5 R9 write count", 32'(wr_count), 32'(len));
      @(negedge clk);
      check(done == 1'b0, "R8 done single", 32'(done), 32'd0);
      check(image_ok == !bad_img, "R8 image flag held", 32'(image_ok), 32'(!bad_img));
   endtask

   initial begin
      int seed;
      seed = int'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(in_ready && !out_valid && !wr_en && !done, "R1 reset outputs",
            {28'd0, in_ready, out_valid, wr_en, done}, 32'h8);
      check(!hdr_ok && !marker_ok && !image_ok, "R1 reset flags",
            {29'd0, hdr_ok, marker_ok, image_ok}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready && !out_valid && !done, "R1 idle after reset",
            {29'd0, in_ready, out_valid, done}, 32'h4);

      run_frame(32'h0001_2345, 3, 1'b0, 8'hCC, 1'b0, 0, 1'b0);  // R2 R5 R6 basic
      run_frame(32'hA5C3_0F10, 5, 1'b1, 8'hCC, 1'b0, 4, 1'b0);  // R3 bad header, R4 held echo
      run_frame(32'h0000_8000, 4, 1'b0, 8'h55, 1'b0, 1, 1'b0);  // R6 missing marker
      run_frame(32'h1234_5678, 0, 1'b0, 8'hCC, 1'b0, 0, 1'b0);  // R9 zero length
      run_frame(32'hDEAD_BEEF, 6, 1'b0, 8'hCC, 1'b1, 0, 1'b0);  // R7 bad image
      run_frame(32'hFFFF_FFFF, 40, 1'b0, 8'hCC, 1'b0, 2, 1'b1); // R7 modulo-255 with 0xFF
      run_frame(32'h0BAD_F00D, 64, 1'b0, 8'hFF, 1'b0, 0, 1'b0); // R6 R7 0xFF first byte

      for (int f = 0; f < 12; f++) begin
         run_frame($urandom, $urandom_range(1, 64), ($urandom_range(0, 3) == 0),
                   ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'hCC,
                   ($urandom_range(0, 3) == 0), $urandom_range(0, 3), 1'b0);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule